// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Scheduler

This block decides the instant at which each new power-switch gate pulse begins and how long that pulse may last. A valley detector supplies one-clock pulses when the switch voltage reaches a resonant minimum. A comparator raises a request when the on-time should end. A supervisor supplies an enable. The scheduler drives the gate and emits a one-clock strobe each time the gate rises, which fault counters elsewhere can use.

Every cycle timer is measured from the rising edge of the previous gate pulse. A blanking window sets the shortest switching period. After that window, the first valley starts a new pulse. Two fallbacks apply when no valley is accepted. If valleys were seen only inside blanking, a short fallback fires after the window. If no valley was seen at all, a long starter timeout fires. The on-time is held between a lower and an upper bound. The default timing assumes a 20 MHz clock: 170 cycles of blanking, a 100-cycle fallback, a 2600-cycle starter, and an on-time of 50 to 940 cycles.

Top module: `qr_cycle_sched`

## Requirements
In the requirements below, edge R is the clock edge at which the gate rises. Edge R+m is the m-th sampling edge after it. All inputs are active high and sampled on the rising clock edge.
- R1: While in reset or while `enable` is low, `gate_out` and `cycle_stb` are 0. When `enable` falls, `gate_out` falls within the same clock cycle, before the next edge.
- R2: After the edge that first samples `enable` high, the first gate rise comes exactly START_CYC (2600) edges later. Valley pulses seen before that rise are ignored.
- R3: A valley sampled at edges R+1 through R+BLANK_CYC (R+170) never starts a pulse.
- R4: If the gate is low and a valley is sampled at edge R+m with m > BLANK_CYC, the gate rises at that same edge R+m.
- R5: Suppose a valley was sampled inside blanking and no valley has been accepted since. Then the gate rises at edge R+BLANK_CYC+FALLBACK_CYC (R+270). If the gate is still high at that point, it rises at the first edge that finds it low.
- R6: If no valley was sampled in the period at all, the gate rises at edge R+START_CYC (R+2600).
- R7: The gate stays high for at least TON_MIN (50) cycles. A done request that pulses earlier than that is remembered and ends the pulse at edge R+50.
- R8: If a done request is sampled at edge R+m with m >= TON_MIN while the gate is high, the gate falls at edge R+m.
- R9: If no done request arrives, the gate falls at edge R+TON_MAX (R+940).
- R10: A valley sampled while the gate is high after blanking is discarded. It neither ends the pulse nor starts the next one.
- R11: `cycle_stb` is high for exactly the first clock cycle of every gate pulse and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 20 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Supervisor permission to switch |
| valley_pulse | input | 1 | One-clock valley indication |
| ton_done_req | input | 1 | Request to end the current on-time |
| gate_out | output | 1 | Power switch gate command |
| cycle_stb | output | 1 | One-clock strobe at each gate rise |

## Verification
The assertions assume that `enable`, `valley_pulse` and `ton_done_req` are synchronous to `clk`. They also assume that `enable` changes only between clock edges, so a gate pulse is never cut by a glitch shorter than one cycle. Under that assumption, any falling edge of the gate seen with `enable` high for two samples must come from the on-time logic. Any strobe seen after a previous strobe, with no disable between them, must respect both the blanking bound and the starter bound. The bench drives every input on the falling clock edge and holds `enable` steady across whole cycles, so the stimulus stays within these assumptions.

// File: rtl/qr_sched_pkg.sv
package qr_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_ON   = 2'd2,
        ST_OFF  = 2'd3
    } qr_state_e;

    typedef struct packed {
        qr_state_e st;
        logic      gate;
        logic      stb;
        logic      blank_valley;
        logic      done_seen;
    } qr_regs_t;

endpackage

// File: rtl/qr_period_ctr.sv
module qr_period_ctr #(
    parameter int SAT_VAL = 2600,
    parameter int CNT_W   = $clog2(SAT_VAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] L_SAT = CNT_W'(SAT_VAL);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q != L_SAT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/qr_trigger_sel.sv
module qr_trigger_sel
    import qr_sched_pkg::*;
#(
    parameter int CNT_W        = 12,
    parameter int BLANK_CYC    = 170,
    parameter int FALLBACK_CYC = 100,
    parameter int START_CYC    = 2600
) (
    input  qr_state_e        st,
    input  logic [CNT_W-1:0] cnt,
    input  logic             valley,
    input  logic             blank_valley,
    output logic             in_blank,
    output logic             start
);
    localparam logic [CNT_W-1:0] L_BLANK  = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] L_FB_M1  = CNT_W'(BLANK_CYC + FALLBACK_CYC - 1);
    localparam logic [CNT_W-1:0] L_ST_M1  = CNT_W'(START_CYC - 1);

    logic starter_due, fallback_due, valley_ok;

    always_comb begin
        in_blank     = (cnt < L_BLANK);
        starter_due  = (cnt >= L_ST_M1);
        fallback_due = blank_valley && (cnt >= L_FB_M1);
        valley_ok    = valley && !in_blank;
        unique case (st)
            ST_ARM:  start = starter_due;
            ST_OFF:  start = valley_ok || fallback_due || starter_due;
            default: start = 1'b0;
        endcase
    end
endmodule

// File: rtl/qr_ontime_ctl.sv
module qr_ontime_ctl #(
    parameter int CNT_W   = 12,
    parameter int TON_MIN = 50,
    parameter int TON_MAX = 940
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             done_req,
    input  logic             done_seen,
    output logic             end_on
);
    localparam logic [CNT_W-1:0] L_MIN_M1 = CNT_W'(TON_MIN - 1);
    localparam logic [CNT_W-1:0] L_MAX_M1 = CNT_W'(TON_MAX - 1);

    logic min_met, max_hit;

    always_comb begin
        min_met = (cnt >= L_MIN_M1);
        max_hit = (cnt >= L_MAX_M1);
        end_on  = (min_met && (done_req || done_seen)) || max_hit;
    end
endmodule

// File: rtl/qr_cycle_sched.sv
module qr_cycle_sched
    import qr_sched_pkg::*;
#(
    parameter int BLANK_CYC    = 170,
    parameter int FALLBACK_CYC = 100,
    parameter int START_CYC    = 2600,
    parameter int TON_MIN      = 50,
    parameter int TON_MAX      = 940
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic valley_pulse,
    input  logic ton_done_req,
    output logic gate_out,
    output logic cycle_stb
);
    localparam int CNT_W = $clog2(START_CYC + 1);

    qr_regs_t         r_d, r_q;
    logic             clr;
    logic [CNT_W-1:0] cnt;
    logic             in_blank;
    logic             start;
    logic             end_on;

    qr_period_ctr #(
        .SAT_VAL (START_CYC),
        .CNT_W   (CNT_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .cnt   (cnt)
    );

    qr_trigger_sel #(
        .CNT_W        (CNT_W),
        .BLANK_CYC    (BLANK_CYC),
        .FALLBACK_CYC (FALLBACK_CYC),
        .START_CYC    (START_CYC)
    ) u_trig (
        .st           (r_q.st),
        .cnt          (cnt),
        .valley       (valley_pulse),
        .blank_valley (r_q.blank_valley),
        .in_blank     (in_blank),
        .start        (start)
    );

    qr_ontime_ctl #(
        .CNT_W   (CNT_W),
        .TON_MIN (TON_MIN),
        .TON_MAX (TON_MAX)
    ) u_ton (
        .cnt       (cnt),
        .done_req  (ton_done_req),
        .done_seen (r_q.done_seen),
        .end_on    (end_on)
    );

    always_comb begin
        r_d     = r_q;
        r_d.stb = 1'b0;
        clr     = 1'b0;
        if (!enable) begin
            r_d.st           = ST_IDLE;
            r_d.gate         = 1'b0;
            r_d.blank_valley = 1'b0;
            r_d.done_seen    = 1'b0;
            clr              = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.st = ST_ARM;
                    clr    = 1'b1;
                end
                ST_ARM, ST_OFF: begin
                    if (start) begin
                        r_d.st           = ST_ON;
                        r_d.gate         = 1'b1;
                        r_d.stb          = 1'b1;
                        r_d.blank_valley = 1'b0;
                        r_d.done_seen    = 1'b0;
                        clr              = 1'b1;
                    end else if (r_q.st == ST_OFF && valley_pulse && in_blank) begin
                        r_d.blank_valley = 1'b1;
                    end
                end
                ST_ON: begin
                    if (valley_pulse && in_blank) begin
                        r_d.blank_valley = 1'b1;
                    end
                    if (ton_done_req) begin
                        r_d.done_seen = 1'b1;
                    end
                    if (end_on) begin
                        r_d.st        = ST_OFF;
                        r_d.gate      = 1'b0;
                        r_d.done_seen = 1'b0;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, gate: 1'b0, stb: 1'b0,
                     blank_valley: 1'b0, done_seen: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_out  = r_q.gate & enable;
    assign cycle_stb = r_q.stb & enable;
endmodule

// File: rtl/qr_sched_chk.sv
module qr_sched_chk #(
    parameter int BLANK_CYC = 170,
    parameter int START_CYC = 2600,
    parameter int TON_MIN   = 50,
    parameter int TON_MAX   = 940
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic gate_out,
    input logic cycle_stb
);
    int   since;
    int   hi_len;
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since  <= 0;
            hi_len <= 0;
            armed  <= 1'b0;
        end else begin
            if (!enable) armed <= 1'b0;
            else if (cycle_stb) armed <= 1'b1;
            if (cycle_stb) since <= 1;
            else if (since < 100000) since <= since + 1;
            if (gate_out) hi_len <= (hi_len < 100000) ? hi_len + 1 : hi_len;
            else hi_len <= 0;
        end
    end

    a_r3_blank_period: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_stb && armed) |-> (since >= BLANK_CYC + 1));

    a_r6_starter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && enable) |-> (since <= START_CYC));

    a_r7_min_on: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_out) && enable && $past(enable)) |-> (hi_len >= TON_MIN));

    a_r9_max_on: assert property (@(posedge clk) disable iff (!rst_n)
        gate_out |-> (hi_len < TON_MAX));

    a_r11_stb_first: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_stb |-> (gate_out && !$past(gate_out)));

    a_r11_rise_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> cycle_stb);
endmodule

bind qr_cycle_sched qr_sched_chk #(
    .BLANK_CYC (BLANK_CYC),
    .START_CYC (START_CYC),
    .TON_MIN   (TON_MIN),
    .TON_MAX   (TON_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .gate_out  (gate_out),
    .cycle_stb (cycle_stb)
);

// File: tb/sim_qr_cycle_sched.sv
module sim_qr_cycle_sched;
    logic clk = 1'b0;
    logic rst_n, enable, valley_pulse, ton_done_req;
    logic gate_out, cycle_stb;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int rise_cyc = 0, fall_cyc = 0, n_rise = 0, n_fall = 0, n_stb = 0, stb_err = 0;
    logic prev_gate = 1'b0;

    always #10 clk = ~clk;

    qr_cycle_sched u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .valley_pulse (valley_pulse),
        .ton_done_req (ton_done_req),
        .gate_out     (gate_out),
        .cycle_stb    (cycle_stb)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (gate_out && !prev_gate) begin rise_cyc = cyc; n_rise++; end
        if (!gate_out && prev_gate) begin fall_cyc = cyc; n_fall++; end
        if (cycle_stb) n_stb++;
        if (cycle_stb != (gate_out && !prev_gate)) stb_err++;
        prev_gate = gate_out;
    end

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wait_rise(output int r);
        int n0;
        n0 = n_rise;
        while (n_rise == n0) @(negedge clk);
        r = rise_cyc;
    endtask

    task automatic wait_fall(output int f);
        int n0;
        n0 = n_fall;
        while (n_fall == n0) @(negedge clk);
        f = fall_cyc;
    endtask

    task automatic valley_at(int t);
        wait_until(t);
        valley_pulse = 1'b1;
        @(negedge clk);
        valley_pulse = 1'b0;
    endtask

    task automatic done_at(int t);
        wait_until(t);
        ton_done_req = 1'b1;
        @(negedge clk);
        ton_done_req = 1'b0;
    endtask

    int r, r2, f, e;

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b0; valley_pulse = 1'b0; ton_done_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 gate in reset", int'(gate_out), 0);
        chk("R1 strobe in reset", int'(cycle_stb), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 gate while disabled", int'(gate_out), 0);
    endtask

    task automatic t_first_pulse();
        ton_done_req = 1'b1;
        e = cyc;
        enable = 1'b1;
        valley_at(e + 300);
        valley_at(e + 1000);
        wait_rise(r);
        chk("R2 first pulse after starter", r - e, 2601);
        wait_fall(f);
        chk("R7 min on-time with held request", f - r, 50);
    endtask

    task automatic t_starter();
        wait_rise(r2);
        chk("R6 starter period", r2 - r, 2600);
        r = r2;
    endtask

    task automatic t_valley_accept();
        valley_at(r + 200);
        wait_rise(r2);
        chk("R4 valley after blanking", r2 - r, 201);
        r = r2;
    endtask

    task automatic t_blank_edge();
        valley_at(r + 169);
        wait_rise(r2);
        chk("R3 last blanked valley ignored, R5 fallback", r2 - r, 270);
        r = r2;
        valley_at(r + 170);
        wait_rise(r2);
        chk("R4 first valley past blanking", r2 - r, 171);
        r = r2;
    endtask

    task automatic t_blank_then_valley();
        valley_at(r + 100);
        valley_at(r + 230);
        wait_rise(r2);
        chk("R5 later valley beats fallback", r2 - r, 231);
        r = r2;
        wait_fall(f);
        ton_done_req = 1'b0;
    endtask

    task automatic t_max_on();
        wait_rise(r);
        valley_at(r + 500);
        wait_fall(f);
        chk("R9 max on-time", f - r, 940);
        wait_rise(r2);
        chk("R10 valley during on ignored", r2 - r, 2600);
        r = r2;
    endtask

    task automatic t_done_pulses();
        done_at(r + 5);
        wait_fall(f);
        chk("R7 early request held to min", f - r, 50);
        valley_at(r + 300);
        wait_rise(r2);
        chk("R4 valley after short pulse", r2 - r, 301);
        r = r2;
        done_at(r + 300);
        wait_fall(f);
        chk("R8 request ends pulse", f - r, 301);
        valley_at(r + 400);
        wait_rise(r2);
        chk("R4 valley after long pulse", r2 - r, 401);
        r = r2;
    endtask

    task automatic t_long_on_fallback();
        valley_at(r + 100);
        wait_rise(r2);
        chk("R5 fallback deferred by long on-time", r2 - r, 941);
        r = r2;
    endtask

    task automatic t_disable();
        wait_until(r + 20);
        enable = 1'b0;
        #1;
        chk("R1 gate drops with enable", int'(gate_out), 0);
        repeat (10) @(negedge clk);
        chk("R1 gate stays low disabled", int'(gate_out), 0);
        chk("R1 strobe low disabled", int'(cycle_stb), 0);
        e = cyc;
        enable = 1'b1;
        valley_at(e + 300);
        wait_rise(r2);
        chk("R2 re-enable waits for starter", r2 - e, 2601);
    endtask

    task automatic t_strobe();
        chk("R11 strobe aligned with rises", stb_err, 0);
        chk("R11 one strobe per pulse", n_stb, n_rise);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_first_pulse();
        t_starter();
        t_valley_accept();
        t_blank_edge();
        t_blank_then_valley();
        t_max_on();
        t_done_pulses();
        t_long_on_fallback();
        t_disable();
        repeat (5) @(negedge clk);
        t_strobe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule